// File: doc/BRIEF.md
# Two-Stage Watchdog Reset Timer

The block is a watchdog that counts a 10-bit value down at a fixed tick rate. The tick rate comes from an internal prescaler that divides the system clock. When the count is at zero on a tick, the half-period has expired and the counter restarts from the programmed value. The first expiry only raises a status flag and an interrupt-style indication. A second expiry while that flag is still set raises a second flag and, unless the reboot-inhibit input is high, emits a one-cycle reset request. The effective timeout is therefore two countdown halves.

Software reaches the block through a small register port with one shared address for reads and writes. Address 0 holds the programmed start value. A write of any data to address 1 restarts the count, and a read there returns the live count. Address 2 holds the two status flags, each cleared by writing one. A correct service routine clears the first flag and then restarts the count. A restart alone leaves the first flag set, so the next expiry counts as the second one.

Top module: `dual_expiry_wdt`

## Requirements
- R1: The count changes only on a tick, and a tick occurs once every TICK_DIV clocks. Each tick that is not an expiry and not a restart lowers the count by one.
- R2: A write to address 1 with any data loads the programmed value into the count. In the same cycle this write overrides a tick, including a tick that would otherwise expire.
- R3: A write to address 0 with a value of 4 to 1023 in data bits 9:0 replaces the programmed value. Values 0 to 3 are ignored and the previous value is kept. A read of address 0 returns the programmed value.
- R4: A read of address 1 returns the live count in bits 9:0 with bits 15:10 zero. A read of address 3 returns zero.
- R5: A tick while the count is 0 is an expiry. On an expiry the count restarts from the programmed value, so each half-period lasts (value+1) ticks.
- R6: An expiry while status bit 3 (first-timeout) is clear sets bit 3. The output first_to_o follows bit 3.
- R7: An expiry while bit 3 is set sets status bit 1 (second-timeout). A restart through address 1 clears neither flag.
- R8: rst_req_o is high for exactly one clock, in the cycle after an expiry that found bit 3 set, and only if no_reboot_i was 0 in the expiry cycle.
- R9: A write to address 2 with data bit 3 or bit 1 at one clears that flag. Zero bits leave the flags unchanged. An expiry that sets a flag in the same cycle wins over the clear.
- R10: After reset the programmed value and the count equal RESET_LIMIT, both flags are clear and rst_req_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 2 | Register select for reads and writes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| no_reboot_i | input | 1 | When high, a second expiry sets the status flag but emits no reset request |
| rst_req_o | output | 1 | One-cycle reset request |
| first_to_o | output | 1 | Level copy of the first-timeout flag |

## Verification
The assertions check on every cycle that the count holds when there is neither a tick nor a restart, and that a restart loads the programmed value. They also check that the programmed value never drops below 4, that each flag rises only for its own cause, and that the reset request is a single cycle gated by the reboot inhibit. Only the bench scenarios can show the exact tick spacing and the full two-half timeout length. The same holds for rejected start values, write-one-to-clear with mixed data bits, and a restart that leaves the first flag set so the next expiry fires the reset. For these the bench compares all outputs and read data against a behavioural model on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W      = 10;
  localparam int DATA_W     = 16;
  localparam int MIN_LIMIT  = 4;
  localparam int FIRST_BIT  = 3;
  localparam int SECOND_BIT = 1;

  typedef enum logic [1:0] {
    REG_LIMIT = 2'd0,
    REG_KICK  = 2'd1,
    REG_STAT  = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_bypass
      logic unused_pre;
      assign unused_pre = clk_i ^ rst_ni;
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre_q;
      assign tick_o = (pre_q == LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pre_q <= '0;
        else if (tick_o) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/wdt_limit_reg.sv
module wdt_limit_reg
  import wdt_pkg::*;
#(
  parameter int RESET_LIMIT = 1023
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] limit_o
);
  logic accept;
  assign accept = wr_i && (wdata_i >= CNT_W'(MIN_LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     limit_o <= CNT_W'(RESET_LIMIT);
    else if (accept) limit_o <= wdata_i;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
#(
  parameter int RESET_LIMIT = 1023
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  // restart write masks a same-cycle expiry
  assign expire_o = tick_i && !kick_i && (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= CNT_W'(RESET_LIMIT);
    else if (kick_i || expire_o) cnt_o <= limit_i;
    else if (tick_i)             cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_first_i,
  input  logic clr_second_i,
  input  logic no_reboot_i,
  output logic first_o,
  output logic second_o,
  output logic rst_req_o
);
  logic hit_first, hit_second;
  assign hit_first  = expire_i && !first_o;
  assign hit_second = expire_i && first_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_o   <= 1'b0;
      second_o  <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      first_o   <= (first_o && !clr_first_i) || hit_first;
      second_o  <= (second_o && !clr_second_i) || hit_second;
      rst_req_o <= hit_second && !no_reboot_i;
    end
  end
endmodule

// File: rtl/dual_expiry_wdt.sv
module dual_expiry_wdt
  import wdt_pkg::*;
#(
  parameter int TICK_DIV    = 1000,
  parameter int RESET_LIMIT = 1023
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              no_reboot_i,
  output logic              rst_req_o,
  output logic              first_to_o
);
  logic             tick, kick, wr_lim, wr_stat, expire;
  logic             first_q, second_q;
  logic [CNT_W-1:0] cnt_q, limit_q;
  logic             unused_wdata;

  assign wr_lim  = wr_en_i && (addr_i == REG_LIMIT);
  assign kick    = wr_en_i && (addr_i == REG_KICK);
  assign wr_stat = wr_en_i && (addr_i == REG_STAT);
  assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  wdt_limit_reg #(.RESET_LIMIT(RESET_LIMIT)) u_lim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_lim),
    .wdata_i(wdata_i[CNT_W-1:0]),
    .limit_o(limit_q)
  );

  wdt_countdown #(.RESET_LIMIT(RESET_LIMIT)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .kick_i  (kick),
    .limit_i (limit_q),
    .cnt_o   (cnt_q),
    .expire_o(expire)
  );

  wdt_status u_sts (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .expire_i    (expire),
    .clr_first_i (wr_stat && wdata_i[FIRST_BIT]),
    .clr_second_i(wr_stat && wdata_i[SECOND_BIT]),
    .no_reboot_i (no_reboot_i),
    .first_o     (first_q),
    .second_o    (second_q),
    .rst_req_o   (rst_req_o)
  );

  assign first_to_o = first_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_LIMIT: rdata_o[CNT_W-1:0] = limit_q;
      REG_KICK:  rdata_o[CNT_W-1:0] = cnt_q;
      REG_STAT: begin
        rdata_o[FIRST_BIT]  = first_q;
        rdata_o[SECOND_BIT] = second_q;
      end
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             kick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] limit_i,
  input logic             first_i,
  input logic             second_i,
  input logic             rst_req_i,
  input logic             no_reboot_i
);
  a_r1_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !kick_i |=> $stable(cnt_i));

  a_r2_kick_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> cnt_i == $past(limit_i));

  a_r3_limit_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_i >= CNT_W'(MIN_LIMIT));

  a_r6_first_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(first_i) |-> $past(tick_i && !kick_i && cnt_i == '0));

  a_r7_second_needs_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(second_i) |-> $past(first_i));

  a_r8_reset_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> $past(first_i && !no_reboot_i));

  a_r8_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> !rst_req_i);
endmodule

bind dual_expiry_wdt wdt_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick),
  .kick_i     (kick),
  .cnt_i      (cnt_q),
  .limit_i    (limit_q),
  .first_i    (first_q),
  .second_i   (second_q),
  .rst_req_i  (rst_req_o),
  .no_reboot_i(no_reboot_i)
);

// File: tb/dual_expiry_wdt_tb.sv
`timescale 1ns/1ps
module dual_expiry_wdt_tb_top;
  localparam int DIV = 3;
  localparam int RL  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        no_reboot = 1'b0;
  logic        rst_req, first_to;

  int vectors = 0;
  int errors  = 0;
  int pulses  = 0;

  int m_pre, m_cnt, m_lim;
  bit m_first, m_second, m_rst;

  always #2.5 clk = ~clk;

  dual_expiry_wdt #(.TICK_DIV(DIV), .RESET_LIMIT(RL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .no_reboot_i(no_reboot),
    .rst_req_o(rst_req), .first_to_o(first_to)
  );

  task automatic check(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int m_read(int a);
    case (a)
      0: return m_lim;
      1: return m_cnt;
      2: return (m_first ? 8 : 0) + (m_second ? 2 : 0);
      default: return 0;
    endcase
  endfunction

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = RL; m_lim = RL;
      m_first = 0; m_second = 0; m_rst = 0;
    end else begin
      bit tk, kk, ex, c3, c1, nf, ns;
      int wv;
      tk = (m_pre == DIV - 1);
      m_pre = tk ? 0 : m_pre + 1;
      kk = wr_en && addr == 2'd1;
      ex = tk && !kk && m_cnt == 0;
      c3 = wr_en && addr == 2'd2 && wdata[3];
      c1 = wr_en && addr == 2'd2 && wdata[1];
      nf = (m_first && !c3) || (ex && !m_first);
      ns = (m_second && !c1) || (ex && m_first);
      m_rst = ex && m_first && !no_reboot;
      if (kk || ex) m_cnt = m_lim;
      else if (tk)  m_cnt = m_cnt - 1;
      wv = int'(wdata[9:0]);
      if (wr_en && addr == 2'd0 && wv >= 4) m_lim = wv;
      m_first = nf; m_second = ns;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (rst_req) pulses++;
      check("R8 rst_req_o", int'(rst_req), int'(m_rst));
      check("R6 first_to_o", int'(first_to), int'(m_first));
      case (addr)
        2'd0: check("R3 limit read", int'(rdata), m_read(0));
        2'd1: check("R1/R2/R4/R5 count read", int'(rdata), m_read(1));
        2'd2: check("R7/R9 status read", int'(rdata), m_read(2));
        default: check("R4 empty read", int'(rdata), 0);
      endcase
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); addr = a; #1; v = int'(rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int v, v0, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    check("R10 count after reset", int'(rdata), RL);  // addr 0 = limit
    check("R10 first_to_o", int'(first_to), 0);
    check("R10 rst_req_o", int'(rst_req), 0);
    rd(2'd2, v); check("R10 status", v, 0);

    // R3 invalid values ignored, valid accepted
    wr(2'd0, 16'd2); rd(2'd0, v); check("R3 value 2 ignored", v, RL);
    wr(2'd0, 16'd3); rd(2'd0, v); check("R3 value 3 ignored", v, RL);
    wr(2'd0, 16'd0); rd(2'd0, v); check("R3 value 0 ignored", v, RL);
    wr(2'd0, 16'd8); rd(2'd0, v); check("R3 value 8 accepted", v, 8);

    // R2 any-data restart, read right after
    @(negedge clk); wr_en = 1'b1; addr = 2'd1; wdata = 16'hABCD;
    @(negedge clk); wr_en = 1'b0; #1;
    check("R2 restart loads value", int'(rdata), 8);
    check("R4 upper bits zero", int'(rdata[15:10]), 0);

    // R1 three ticks in nine clocks
    v0 = int'(rdata);
    idle(9); #1;
    check("R1 tick spacing", int'(rdata), v0 - 3);

    // R2 continuous restart blocks expiry
    @(negedge clk); wr_en = 1'b1; addr = 2'd1;
    idle(60);
    wr_en = 1'b0; #1;
    check("R2 no expiry under restart", int'(first_to), 0);
    check("R2 count held at value", int'(rdata), 8);

    // R5/R6 first expiry
    n = 0;
    while (!first_to && n < 200) begin @(negedge clk); n++; end
    #1;
    check("R6 first expiry seen", int'(first_to), 1);
    check("R5 restart after expiry", int'(rdata), 8);
    check("R8 no reset on first expiry", pulses, 0);

    // R7 restart keeps flag
    wr(2'd1, 16'h0000);
    rd(2'd2, v); check("R7 restart keeps bit 3", v, 8);

    // R7/R8 second expiry
    n = 0;
    while (pulses == 0 && n < 200) begin @(negedge clk); n++; end
    idle(2);
    check("R8 one reset pulse", pulses, 1);
    rd(2'd2, v); check("R7 both flags", v, 10);

    // R9 write-one-to-clear
    wr(2'd2, 16'h0000); rd(2'd2, v); check("R9 zero write no effect", v, 10);
    wr(2'd2, 16'h0008); rd(2'd2, v); check("R9 clear bit 3", v, 2);
    wr(2'd2, 16'h0002); rd(2'd2, v); check("R9 clear bit 1", v, 0);

    // R8 reboot inhibit
    no_reboot = 1'b1;
    wr(2'd1, 16'h0001);
    idle(70);
    check("R8 inhibited, no new pulse", pulses, 1);
    rd(2'd2, v); check("R8 flags still set", v, 10);
    rd(2'd3, v); check("R4 empty address", v, 0);

    no_reboot = 1'b0;
    idle(4);
    summary();
    $finish;
  end
endmodule